// File: doc/BRIEF.md
# Configuration Word Stream Parser

This block sits behind a configuration port deserialiser and consumes one 32-bit word per accepted handshake. It discards everything until a fixed synchronisation word arrives. After that, every word is either a packet header or one payload word of the packet being processed. Payload words of write packets go out on a register-write strobe port. Words addressed to the frame data input register go out instead on a frame-word stream, which carries the current frame address and marks the last word of every frame.

Frame words pass only after the device identifier has been written with the expected value. A running CRC-32C covers every written word. A write to the CRC register compares that running value with the written word. A mismatch aborts configuration: the input stops accepting words until reset. Sticky flags report synchronisation, header misuse, identifier problems, CRC failure and abort. Every output is registered, so a word accepted at a clock edge is reflected on the outputs right after that edge.

Top module: `cfg_stream_parser`

## Requirements
- R1: No input word produces an output until a word equal to SYNC_WORD (default 0xAA995566) is accepted. `synced` rises after the edge that accepts it and stays high until reset.
- R2: After sync, a header with bits [31:29]=001 is Type 1, with opcode in [28:27] (00 no-op, 01 read, 10 write), register in [17:13] and word count in [10:0]. A write header with count N takes the next N accepted words as payload. Each payload word not bound for register 2 appears one cycle later on `wr_valid`/`wr_addr`/`wr_data`. Read and no-op headers take no payload. Header words of any type other than 001 or 010 are skipped.
- R3: A Type 1 write header with word count 0 takes no payload, so the next accepted word is decoded as a header.
- R4: A header with bits [31:29]=010 is Type 2, with word count in [26:0]. When it directly follows a Type 1 header, it reuses that header's register and write opcode. Payload for register 2 (frame data) appears only on `fw_valid`/`fw_data`, with `fw_far` holding the last value written to register 1 (frame address: block type, half, row, column and minor fields).
- R5: `fw_last` is high on every FRAME_WORDS-th frame word (default 101) counted since reset, and low on all other frame words.
- R6: Frame words that arrive before register 12 has been written with DEVICE_ID are discarded and set `id_err`. A write of any other value to register 12 also sets `id_err`.
- R7: A Type 2 header whose previous accepted word was not a Type 1 header sets `hdr_err`. Its payload words are consumed and discarded.
- R8: The running CRC starts at 0. For every written payload word to a register other than 0, it absorbs the 37-bit value {register, data} LSB first (data bit 0 first) with reflected polynomial 0x82F63B78 and no final inversion. A write to register 0 is compared with the running value and then restarts it at 0. A match leaves `crc_err` low.
- R9: A CRC mismatch sets `crc_err` and `abort`. After that, `in_ready` stays low and no output strobe fires until reset.
- R10: After reset, all strobes and flags are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Parser accepts a word this cycle |
| synced | output | 1 | Synchronisation word seen |
| wr_valid | output | 1 | Register-write strobe |
| wr_addr | output | 5 | Register of the write |
| wr_data | output | 32 | Data of the write |
| fw_valid | output | 1 | Frame-word strobe |
| fw_data | output | 32 | Frame word |
| fw_far | output | 32 | Frame address in force for the word |
| fw_last | output | 1 | Final word of a frame |
| hdr_err | output | 1 | Sticky: misplaced Type 2 header |
| id_err | output | 1 | Sticky: identifier mismatch or early frame data |
| crc_err | output | 1 | Sticky: CRC comparison failed |
| abort | output | 1 | Sticky: configuration aborted |

## Verification
The hardest state to reach is a correct CRC comparison that follows a long Type 2 frame burst. The stimulus has to embed the exact running CRC-32C of every earlier write, including frame words and identifier writes, into the stream. The bench builds that value while it issues words, then emits a deliberately flipped value to force the abort path. Idle cycles are interleaved in the stream, so handshake gaps inside multi-word packets are also covered.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned RADDR_W = 5;
    localparam int unsigned T1_CNT_W = 11;
    localparam int unsigned T2_CNT_W = 27;

    localparam logic [RADDR_W-1:0] RA_CRC   = 5'd0;
    localparam logic [RADDR_W-1:0] RA_FAR   = 5'd1;
    localparam logic [RADDR_W-1:0] RA_FDRI  = 5'd2;
    localparam logic [RADDR_W-1:0] RA_DEVID = 5'd12;

    localparam logic [WORD_W-1:0] CRC_POLY_REFL = 32'h82F63B78;
    localparam int unsigned CRC_IN_W = RADDR_W + WORD_W;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_RSVD  = 2'b11
    } opc_e;

    typedef enum logic [1:0] {
        HK_OTHER = 2'd0,
        HK_T1    = 2'd1,
        HK_T2    = 2'd2
    } hkind_e;

    typedef enum logic [1:0] {
        PS_HUNT = 2'd0,
        PS_HDR  = 2'd1,
        PS_PAY  = 2'd2
    } pstate_e;

    typedef struct packed {
        hkind_e               kind;
        opc_e                 op;
        logic [RADDR_W-1:0]   addr;
        logic [T2_CNT_W-1:0]  count;
    } hdr_t;

    function automatic hdr_t decode_hdr(input logic [WORD_W-1:0] w);
        hdr_t h;
        h.kind  = HK_OTHER;
        h.op    = opc_e'(w[28:27]);
        h.addr  = w[17:13];
        h.count = '0;
        case (w[31:29])
            3'b001: begin
                h.kind  = HK_T1;
                h.count = T2_CNT_W'(w[T1_CNT_W-1:0]);
            end
            3'b010: begin
                h.kind  = HK_T2;
                h.count = w[T2_CNT_W-1:0];
            end
            default: h.kind = HK_OTHER;
        endcase
        return h;
    endfunction

    function automatic logic [WORD_W-1:0] crc32c_step(input logic [WORD_W-1:0] c,
                                                      input logic [CRC_IN_W-1:0] v);
        logic [WORD_W-1:0] r;
        r = c;
        for (int i = 0; i < CRC_IN_W; i++) begin
            if (r[0] ^ v[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/cfgp_crc32c.sv
module cfgp_crc32c
    import cfgp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                upd,
    input  logic [RADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]   data,
    output logic [WORD_W-1:0]   crc
);

    logic [WORD_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= '0;
        end else if (upd) begin
            crc_q <= crc32c_step(crc_q, {addr, data});
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/cfgp_frame_ctr.sv
module cfgp_frame_ctr #(
    parameter int unsigned FRAME_WORDS = 101
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic at_last
);

    localparam int unsigned CW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_WORDS - 1);

    logic [CW-1:0] cnt_q;

    assign at_last = (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
    import cfgp_pkg::*;
#(
    parameter logic [31:0] SYNC_WORD   = 32'hAA995566,
    parameter logic [31:0] DEVICE_ID   = 32'h0372C093,
    parameter int unsigned FRAME_WORDS = 101
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic        synced,
    output logic        wr_valid,
    output logic [4:0]  wr_addr,
    output logic [31:0] wr_data,
    output logic        fw_valid,
    output logic [31:0] fw_data,
    output logic [31:0] fw_far,
    output logic        fw_last,
    output logic        hdr_err,
    output logic        id_err,
    output logic        crc_err,
    output logic        abort
);

    pstate_e              st_q;
    logic [T2_CNT_W-1:0]  rem_q;
    logic [RADDR_W-1:0]   reg_q;
    logic                 wen_q;
    logic                 prev_t1_q;
    logic                 id_ok_q;
    logic [WORD_W-1:0]    far_q;

    logic                 synced_q, hdr_err_q, id_err_q, crc_err_q, abort_q;
    logic                 wr_valid_q, fw_valid_q, fw_last_q;
    logic [RADDR_W-1:0]   wr_addr_q;
    logic [WORD_W-1:0]    wr_data_q, fw_data_q, fw_far_q;

    hdr_t                 hdr;
    logic                 accept, pay_wr, crc_hit, crc_upd, fdri_hit, frame_adv, crc_bad;
    logic                 frame_at_last;
    logic [WORD_W-1:0]    crc_now;

    always_comb hdr = decode_hdr(in_data);

    assign accept    = in_valid && !abort_q;
    assign pay_wr    = accept && (st_q == PS_PAY) && wen_q;
    assign crc_hit   = pay_wr && (reg_q == RA_CRC);
    assign crc_upd   = pay_wr && (reg_q != RA_CRC);
    assign fdri_hit  = pay_wr && (reg_q == RA_FDRI);
    assign frame_adv = fdri_hit && id_ok_q;
    assign crc_bad   = crc_hit && (in_data != crc_now);

    cfgp_crc32c u_crc (
        .clk  (clk),
        .rst  (rst),
        .clr  (crc_hit),
        .upd  (crc_upd),
        .addr (reg_q),
        .data (in_data),
        .crc  (crc_now)
    );

    cfgp_frame_ctr #(.FRAME_WORDS(FRAME_WORDS)) u_fctr (
        .clk     (clk),
        .rst     (rst),
        .adv     (frame_adv),
        .at_last (frame_at_last)
    );

    // Packet sequencing: hunt for sync, then alternate header / payload.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= PS_HUNT;
            rem_q     <= '0;
            reg_q     <= '0;
            wen_q     <= 1'b0;
            prev_t1_q <= 1'b0;
            synced_q  <= 1'b0;
            hdr_err_q <= 1'b0;
        end else if (accept) begin
            case (st_q)
                PS_HUNT: begin
                    if (in_data == SYNC_WORD) begin
                        st_q     <= PS_HDR;
                        synced_q <= 1'b1;
                    end
                end
                PS_HDR: begin
                    prev_t1_q <= (hdr.kind == HK_T1);
                    case (hdr.kind)
                        HK_T1: begin
                            reg_q <= hdr.addr;
                            wen_q <= (hdr.op == OP_WRITE);
                            if (hdr.op == OP_WRITE && hdr.count != '0) begin
                                st_q  <= PS_PAY;
                                rem_q <= hdr.count;
                            end
                        end
                        HK_T2: begin
                            if (!prev_t1_q) begin
                                wen_q     <= 1'b0;
                                hdr_err_q <= 1'b1;
                            end
                            if (hdr.count != '0) begin
                                st_q  <= PS_PAY;
                                rem_q <= hdr.count;
                            end
                        end
                        default: ;
                    endcase
                end
                default: begin
                    prev_t1_q <= 1'b0;
                    rem_q     <= rem_q - 1'b1;
                    if (rem_q == T2_CNT_W'(1)) st_q <= PS_HDR;
                end
            endcase
        end
    end

    // Register side effects and registered outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            id_ok_q    <= 1'b0;
            id_err_q   <= 1'b0;
            crc_err_q  <= 1'b0;
            abort_q    <= 1'b0;
            far_q      <= '0;
            wr_valid_q <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
            fw_valid_q <= 1'b0;
            fw_data_q  <= '0;
            fw_far_q   <= '0;
            fw_last_q  <= 1'b0;
        end else begin
            wr_valid_q <= pay_wr && (reg_q != RA_FDRI);
            fw_valid_q <= frame_adv;
            if (pay_wr && reg_q != RA_FDRI) begin
                wr_addr_q <= reg_q;
                wr_data_q <= in_data;
            end
            if (frame_adv) begin
                fw_data_q <= in_data;
                fw_far_q  <= far_q;
                fw_last_q <= frame_at_last;
            end
            if (pay_wr && reg_q == RA_FAR) far_q <= in_data;
            if (pay_wr && reg_q == RA_DEVID) begin
                if (in_data == DEVICE_ID) id_ok_q  <= 1'b1;
                else                      id_err_q <= 1'b1;
            end
            if (fdri_hit && !id_ok_q) id_err_q <= 1'b1;
            if (crc_bad) begin
                crc_err_q <= 1'b1;
                abort_q   <= 1'b1;
            end
        end
    end

    assign in_ready = !abort_q;
    assign synced   = synced_q;
    assign wr_valid = wr_valid_q;
    assign wr_addr  = wr_addr_q;
    assign wr_data  = wr_data_q;
    assign fw_valid = fw_valid_q;
    assign fw_data  = fw_data_q;
    assign fw_far   = fw_far_q;
    assign fw_last  = fw_last_q;
    assign hdr_err  = hdr_err_q;
    assign id_err   = id_err_q;
    assign crc_err  = crc_err_q;
    assign abort    = abort_q;

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
    import cfgp_pkg::*;
#(
    parameter logic [31:0] DEVICE_ID   = 32'h0372C093,
    parameter int unsigned FRAME_WORDS = 101
) (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        synced,
    input logic        wr_valid,
    input logic [4:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        fw_valid,
    input logic        fw_last,
    input logic        crc_err,
    input logic        abort
);

    localparam int unsigned CW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;

    logic          id_seen;
    logic [CW-1:0] fcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_seen <= 1'b0;
            fcnt    <= '0;
        end else begin
            if (wr_valid && wr_addr == RA_DEVID && wr_data == DEVICE_ID) id_seen <= 1'b1;
            if (fw_valid) fcnt <= (fcnt == CW'(FRAME_WORDS - 1)) ? '0 : fcnt + 1'b1;
        end
    end

    a_r1_quiet_before_sync: assert property (@(posedge clk) disable iff (rst)
        !synced |-> (!wr_valid && !fw_valid));

    a_r4_ports_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && fw_valid));

    a_r5_frame_boundary: assert property (@(posedge clk) disable iff (rst)
        fw_valid |-> (fw_last == (fcnt == CW'(FRAME_WORDS - 1))));

    a_r6_frame_after_id: assert property (@(posedge clk) disable iff (rst)
        fw_valid |-> id_seen);

    a_r9_crc_err_aborts: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> (abort && !in_ready));

    a_r9_abort_sticky: assert property (@(posedge clk) disable iff (rst)
        abort |=> (abort && !in_ready && !wr_valid && !fw_valid));

endmodule

bind cfg_stream_parser cfgp_checker #(
    .DEVICE_ID   (DEVICE_ID),
    .FRAME_WORDS (FRAME_WORDS)
) u_cfgp_checker (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .synced   (synced),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .fw_valid (fw_valid),
    .fw_last  (fw_last),
    .crc_err  (crc_err),
    .abort    (abort)
);

// File: tb/test_cfg_stream_parser.sv
`timescale 1ns/1ps
module test_cfg_stream_parser;

    localparam logic [31:0] SYNC  = 32'hAA995566;
    localparam logic [31:0] DEVID = 32'h0372C093;
    localparam int FRAME_N = 101;
    localparam logic [31:0] POLY = 32'h82F63B78;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, synced, wr_valid, fw_valid, fw_last;
    logic        hdr_err, id_err, crc_err, abort;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data, fw_data, fw_far;

    cfg_stream_parser i_cfg_stream_parser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .synced(synced),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .fw_valid(fw_valid), .fw_data(fw_data), .fw_far(fw_far), .fw_last(fw_last),
        .hdr_err(hdr_err), .id_err(id_err), .crc_err(crc_err), .abort(abort)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int n_last = 0;
    int gap_ctr = 0;
    logic [31:0] b_crc = '0;

    // Reference model state
    bit m_sync, m_pay, m_wen, m_prev, m_idok, m_hdr, m_iderr, m_crcerr, m_abort;
    int unsigned m_rem, m_fc;
    logic [4:0]  m_reg;
    logic [31:0] m_crc, m_far;
    bit          e_wr, e_fw, e_last;
    logic [4:0]  e_addr;
    logic [31:0] e_data, e_fdata, e_ffar;

    function automatic logic [31:0] crc_add(input logic [31:0] c, input logic [4:0] a,
                                            input logic [31:0] d);
        logic [36:0] v;
        logic [31:0] r;
        bit fb;
        v = {a, d};
        r = c;
        for (int i = 0; i < 37; i++) begin
            fb = r[0] ^ v[i];
            r = (r >> 1) ^ (POLY & {32{fb}});
        end
        return r;
    endfunction

    function automatic logic [31:0] t1(input int op, input int rg, input int cnt);
        logic [31:0] w;
        w = 32'h2000_0000;
        w[28:27] = op[1:0];
        w[17:13] = rg[4:0];
        w[10:0]  = cnt[10:0];
        return w;
    endfunction

    function automatic logic [31:0] t2(input int cnt);
        return {3'b010, 29'(cnt)};
    endfunction

    task automatic model_reset();
        m_sync = 0; m_pay = 0; m_wen = 0; m_prev = 0; m_idok = 0;
        m_hdr = 0; m_iderr = 0; m_crcerr = 0; m_abort = 0;
        m_rem = 0; m_fc = 0; m_reg = '0; m_crc = '0; m_far = '0;
        e_wr = 0; e_fw = 0; e_last = 0; e_addr = '0; e_data = '0; e_fdata = '0; e_ffar = '0;
    endtask

    task automatic model_write(input logic [31:0] w);
        if (m_reg == 5'd0) begin
            e_wr = 1; e_addr = m_reg; e_data = w;
            if (w != m_crc) begin m_crcerr = 1; m_abort = 1; end
            m_crc = '0;
        end else begin
            m_crc = crc_add(m_crc, m_reg, w);
            if (m_reg == 5'd2) begin
                if (m_idok) begin
                    e_fw = 1; e_fdata = w; e_ffar = m_far;
                    e_last = (m_fc == FRAME_N - 1);
                    m_fc = (m_fc + 1) % FRAME_N;
                end else begin
                    m_iderr = 1;
                end
            end else begin
                e_wr = 1; e_addr = m_reg; e_data = w;
                if (m_reg == 5'd1) m_far = w;
                if (m_reg == 5'd12) begin
                    if (w == DEVID) m_idok = 1; else m_iderr = 1;
                end
            end
        end
    endtask

    task automatic model_accept(input logic [31:0] w);
        int unsigned cnt;
        if (!m_sync) begin
            if (w == SYNC) m_sync = 1;
        end else if (!m_pay) begin
            if (w[31:29] == 3'b001) begin
                m_reg = w[17:13];
                m_wen = (w[28:27] == 2'b10);
                cnt = w[10:0];
                if (m_wen && cnt != 0) begin m_pay = 1; m_rem = cnt; end
                m_prev = 1;
            end else if (w[31:29] == 3'b010) begin
                if (!m_prev) begin m_hdr = 1; m_wen = 0; end
                cnt = w[26:0];
                if (cnt != 0) begin m_pay = 1; m_rem = cnt; end
                m_prev = 0;
            end else begin
                m_prev = 0;
            end
        end else begin
            m_prev = 0;
            m_rem--;
            if (m_rem == 0) m_pay = 0;
            if (m_wen) model_write(w);
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(synced == m_sync, "R1", "synced", 32'(synced), 32'(m_sync));
        chk(wr_valid == e_wr, "R2", "wr_valid", 32'(wr_valid), 32'(e_wr));
        if (e_wr && wr_valid) begin
            chk(wr_addr == e_addr, "R2", "wr_addr", 32'(wr_addr), 32'(e_addr));
            chk(wr_data == e_data, "R2", "wr_data", wr_data, e_data);
        end
        chk(fw_valid == e_fw, "R4", "fw_valid", 32'(fw_valid), 32'(e_fw));
        if (e_fw && fw_valid) begin
            chk(fw_data == e_fdata, "R4", "fw_data", fw_data, e_fdata);
            chk(fw_far == e_ffar, "R4", "fw_far", fw_far, e_ffar);
            chk(fw_last == e_last, "R5", "fw_last", 32'(fw_last), 32'(e_last));
            if (fw_last) n_last++;
        end
        chk(hdr_err == m_hdr, "R7", "hdr_err", 32'(hdr_err), 32'(m_hdr));
        chk(id_err == m_iderr, "R6", "id_err", 32'(id_err), 32'(m_iderr));
        chk(crc_err == m_crcerr, "R8", "crc_err", 32'(crc_err), 32'(m_crcerr));
        chk(abort == m_abort, "R9", "abort", 32'(abort), 32'(m_abort));
        chk(in_ready == !m_abort, "R9", "in_ready", 32'(in_ready), 32'(!m_abort));
    endtask

    // One clock: drive at negedge, model the edge, compare at the next negedge.
    task automatic step(input bit v, input logic [31:0] d);
        bit acc;
        acc = v && !m_abort;
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        e_wr = 0; e_fw = 0;
        if (acc) model_accept(d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic send(input logic [31:0] w);
        gap_ctr++;
        if (gap_ctr % 3 == 0) step(1'b0, 32'h0);
        step(1'b1, w);
    endtask

    task automatic wr1(input int rg, input logic [31:0] d);
        send(t1(2, rg, 1));
        send(d);
        if (rg != 0) b_crc = crc_add(b_crc, 5'(rg), d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        b_crc = '0;
        step(1'b0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        // R10: reset state
        chk(!wr_valid && !fw_valid && !synced && !hdr_err && !id_err && !crc_err && !abort,
            "R10", "flags after reset", {27'b0, wr_valid, fw_valid, synced, crc_err, abort},
            32'h0);
        chk(in_ready == 1'b1, "R10", "in_ready after reset", 32'(in_ready), 32'h1);

        // Scenario A: pre-sync garbage, orphan Type 2, early frame data
        send(t1(2, 1, 1));
        send(32'h1111_1111);
        send(32'hFFFF_FFFF);
        send(32'h0000_00BB);
        chk(synced == 1'b0, "R1", "synced before sync word", 32'(synced), 32'h0);
        send(SYNC);
        chk(synced == 1'b1, "R1", "synced after sync word", 32'(synced), 32'h1);
        send(32'hFFFF_FFFF);
        send(t1(0, 0, 0));
        wr1(5, 32'h0000_A5A5);
        send(t2(2));
        send(32'hDEAD_0001);
        send(32'hDEAD_0002);
        chk(hdr_err == 1'b1, "R7", "orphan Type 2 flag", 32'(hdr_err), 32'h1);
        wr1(2, 32'h5555_0000);
        chk(id_err == 1'b1, "R6", "frame word before id", 32'(id_err), 32'h1);

        // Scenario B: full load, two frames, good then bad CRC
        do_reset();
        send(SYNC);
        wr1(1, 32'h0042_0A05);
        wr1(12, DEVID);
        send(t1(2, 1, 0));
        send(t1(2, 7, 1));
        send(32'h0000_1234);
        b_crc = crc_add(b_crc, 5'd7, 32'h0000_1234);
        chk(wr_valid && wr_addr == 5'd7 && wr_data == 32'h1234, "R3",
            "word after zero-count header", wr_data, 32'h1234);
        send(t1(2, 2, 0));
        send(t2(2 * FRAME_N));
        for (int i = 0; i < 2 * FRAME_N; i++) begin
            send(32'hC0DE_0000 + 32'(i));
            b_crc = crc_add(b_crc, 5'd2, 32'hC0DE_0000 + 32'(i));
        end
        chk(n_last == 2, "R5", "frame boundaries in two frames", 32'(n_last), 32'h2);
        send(t1(1, 12, 1));
        send(t1(0, 0, 0));
        send(t1(2, 0, 1));
        send(b_crc);
        b_crc = '0;
        chk(!crc_err && !abort, "R8", "matching crc", 32'(crc_err), 32'h0);
        wr1(1, 32'h0000_0001);
        send(t1(2, 0, 1));
        send(b_crc ^ 32'h1);
        chk(crc_err && abort, "R9", "crc mismatch abort", 32'(abort), 32'h1);
        chk(in_ready == 1'b0, "R9", "in_ready after abort", 32'(in_ready), 32'h0);
        wr1(3, 32'h0000_0005);
        chk(!wr_valid, "R9", "no write after abort", 32'(wr_valid), 32'h0);

        // Scenario C: wrong id then right id, frame data passes
        do_reset();
        send(SYNC);
        wr1(12, DEVID ^ 32'h10);
        chk(id_err == 1'b1, "R6", "id mismatch", 32'(id_err), 32'h1);
        wr1(12, DEVID);
        send(t1(2, 2, 5));
        for (int i = 0; i < 5; i++) send(32'hF00D_0000 + 32'(i));
        send(t1(2, 0, 0));
        send(t2(1));
        send(32'h0);
        chk(hdr_err == 1'b0, "R4", "Type 2 after Type 1 is legal", 32'(hdr_err), 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule